// File: doc/BRIEF.md
# Physical Address Route Decoder

The decoder takes a physical system address and returns the socket, memory controller and logical channel that own it. It starts with a sanity check against the top of low memory, the top of high memory and the 4 GiB line. It then walks the range rules of the home node one per clock, in index order. The matching rule selects an interleave target from a packed target word. A target can point at another node, and the decoder then restarts the walk on that node's rules, but it does this at most once. A local target yields a logical channel, either directly or through a modulo-3 or modulo-2 fold of the address. The channel then indexes a per-node route word, which gives the controller and channel numbers.

Requests arrive on a valid/ready port. `req_ready` is high only while the decoder is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. The result is presented with `rsp_valid` and stays unchanged until `rsp_ready` is sampled high. While a result is waiting, no new request is taken. Rule words, target words, node source ids and route words are loaded through a one-cycle register-write port.

Top module: `addr_route_decoder`

## Requirements
- R1: An address at or above `high_top` is rejected with `rsp_err`, as is an address that is at or above `low_top` and below 2^32. An address of exactly 2^32 below `high_top` is decoded normally.
- R2: A rule word holds an enable flag in bit 0 and a limit field in bits [26:7]. The rule's upper bound is the limit field shifted left by 26 with the low 26 bits all ones. An enabled rule hits when the address is not below the running lower bound and not above its own upper bound. After every rule, whether it is enabled or not, the lower bound becomes that rule's upper bound plus one. The lower bound starts at 0.
- R3: Rules are examined from index 0 upward and the first hit wins. If no rule of the node hits, the decoder returns `rsp_err`.
- R4: Rule bits [2:1] choose the 3-bit target index. Code 0 takes address bits [8:6], code 1 takes [10:8], code 2 takes [14:12] and code 3 takes [32:30].
- R5: The target is the 4-bit field at bit 4*index of the rule's target word. Target bit 3 set means the target is local, and bit 3 clear means it is remote with node source id target[2:0].
- R6: The walk starts on node 0. On a remote target, the walk restarts at rule 0 with a lower bound of 0 on the lowest-numbered node whose source id equals the target. `rsp_socket` reports the source id of the node that finally resolves the address.
- R7: A remote target found on the second node walked, or a remote source id that no node carries, gives `rsp_err`.
- R8: When rule bit 27 is clear, the logical channel L is target[2:0].
- R9: When rule bit 27 is set, rule bits [31:30] give a shift s: 0 gives 6, 1 gives 8, 2 gives 12, and 3 is an error. With x = address >> s, rule bits [6:5] give a value v: 0 gives x mod 3, 1 gives x mod 2, 2 gives {x[0], !x[0]}, and 3 gives {x[0], 0}. L is then {v, target[0]}.
- R10: With the node's route word zero-extended above bit 31, `rsp_mc` is route bits [3L+2:3L] and `rsp_chan` is route bits [2L+19:2L+18]. On any error, `rsp_socket`, `rsp_mc` and `rsp_chan` are 0.
- R11: `req_ready` is high only when no request is in progress and no result is pending. `rsp_valid` and all response fields hold steady until `rsp_ready` is sampled high.
- R12: A write with `cfg_we` high stores `cfg_data` into the entry of node `cfg_node` that `cfg_kind` selects: 0 is rule word `cfg_idx`, 1 is target word `cfg_idx`, 2 is the source id (bits [2:0]), and 3 is the route word. After reset all rules are disabled and node n has source id n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Decoder can take a request |
| req_addr | input | ADDR_W | Physical address to decode |
| low_top | input | ADDR_W | Top of low memory |
| high_top | input | ADDR_W | Top of high memory |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Entry kind: rule, target, source id, route |
| cfg_node | input | NODE_W | Node whose entry is written |
| cfg_idx | input | IDX_W | Rule index for rule and target writes |
| cfg_data | input | 32 | Write data |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer accepts result |
| rsp_err | output | 1 | Address could not be routed |
| rsp_socket | output | 3 | Source id of the resolving node |
| rsp_mc | output | 3 | Memory controller index |
| rsp_chan | output | 2 | Channel index |

## Verification
A wrong running lower bound, or a wrong rule index, shows up as the wrong rule winning. That appears as a different controller or channel on the very next response, or as a false miss. Addresses placed exactly on rule bounds and inside disabled rules are used to expose it. A wrong hop flag or wrong node register appears as a wrong socket, or as a missing error for a second remote target. Every wrong bit in the modulo fold changes the logical channel, so several addresses per mode are chosen to cover all residues.

// File: rtl/ard_pkg.sv
package ard_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    KIND_RULE  = 2'd0,
    KIND_TGT   = 2'd1,
    KIND_SRCID = 2'd2,
    KIND_ROUTE = 2'd3
  } cfg_kind_e;

  typedef struct packed {
    logic [1:0]  fold_shift;
    logic [1:0]  rsvd;
    logic        fold_en;
    logic [19:0] limit_f;
    logic [1:0]  fold_mode;
    logic [1:0]  attr;
    logic [1:0]  ilv_sel;
    logic        en;
  } rule_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SCAN    = 2'd1,
    ST_RESOLVE = 2'd2,
    ST_RESP    = 2'd3
  } state_e;
endpackage

// File: rtl/ard_rule_table.sv
module ard_rule_table import ard_pkg::*; #(
  parameter int NODES = 2,
  parameter int RULES = 24,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int IDX_W = (RULES > 1) ? $clog2(RULES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [NODE_W-1:0] wr_node,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [NODE_W-1:0] rd_node,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_rule,
  output logic [WORD_W-1:0] rd_tgt,
  output logic [WORD_W-1:0] rd_route,
  output logic [3*NODES-1:0] srcid_all
);
  logic [WORD_W-1:0] node_rule  [NODES];
  logic [WORD_W-1:0] node_tgt   [NODES];
  logic [WORD_W-1:0] node_route [NODES];

  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic [WORD_W-1:0] rule_q [RULES];
    logic [WORD_W-1:0] tgt_q  [RULES];
    logic [2:0]        sid_q;
    logic [WORD_W-1:0] route_q;
    logic              sel;

    assign sel = wr_en && (wr_node == NODE_W'(n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < RULES; r++) begin
          rule_q[r] <= '0;
          tgt_q[r]  <= '0;
        end
        sid_q   <= 3'(n);
        route_q <= '0;
      end else if (sel) begin
        case (cfg_kind_e'(wr_kind))
          KIND_RULE:  if (int'(wr_idx) < RULES) rule_q[wr_idx] <= wr_data;
          KIND_TGT:   if (int'(wr_idx) < RULES) tgt_q[wr_idx] <= wr_data;
          KIND_SRCID: sid_q <= wr_data[2:0];
          default:    route_q <= wr_data;
        endcase
      end
    end

    assign node_rule[n]  = rule_q[rd_idx];
    assign node_tgt[n]   = tgt_q[rd_idx];
    assign node_route[n] = route_q;
    assign srcid_all[3*n +: 3] = sid_q;
  end

  assign rd_rule  = node_rule[rd_node];
  assign rd_tgt   = node_tgt[rd_node];
  assign rd_route = node_route[rd_node];

  // R3: the walk never reads past the last rule
  p_rd_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_idx) < RULES);
endmodule

// File: rtl/ard_chan_sel.sv
module ard_chan_sel import ard_pkg::*; #(
  parameter int ADDR_W = 46
) (
  input  logic [ADDR_W-1:0] addr,
  input  rule_t             rule,
  input  logic [3:0]        tgt,
  output logic [2:0]        lchan,
  output logic              illegal
);
  localparam int PAIRS = (ADDR_W + 1) / 2;

  // x mod 3 from base-4 digits: 4 = 1 (mod 3), so the digits simply add
  function automatic logic [1:0] fold3(input logic [ADDR_W-1:0] v);
    logic [2*PAIRS-1:0] ext;
    logic [2:0]         acc;
    ext = (2*PAIRS)'(v);
    acc = '0;
    for (int i = 0; i < PAIRS; i++) begin
      acc = acc + {1'b0, ext[2*i +: 2]};
      if (acc >= 3'd3) acc = acc - 3'd3;
    end
    return acc[1:0];
  endfunction

  logic [ADDR_W-1:0] x;
  logic [1:0]        v;

  always_comb begin
    illegal = 1'b0;
    case (rule.fold_shift)
      2'd0: x = addr >> 6;
      2'd1: x = addr >> 8;
      2'd2: x = addr >> 12;
      default: begin
        x = '0;
        illegal = rule.fold_en;
      end
    endcase
    case (rule.fold_mode)
      2'd0: v = fold3(x);
      2'd1: v = {1'b0, x[0]};
      2'd2: v = {x[0], ~x[0]};
      default: v = {x[0], 1'b0};
    endcase
    lchan = rule.fold_en ? {v, tgt[0]} : tgt[2:0];
  end
endmodule

// File: rtl/ard_route_pick.sv
module ard_route_pick import ard_pkg::*; (
  input  logic [WORD_W-1:0] route,
  input  logic [2:0]        lchan,
  output logic [2:0]        mc,
  output logic [1:0]        chan
);
  logic [WORD_W+7:0] ext;
  assign ext  = {8'b0, route};
  assign mc   = ext[3*int'(lchan) +: 3];
  assign chan = ext[2*int'(lchan) + 18 +: 2];
endmodule

// File: rtl/addr_route_decoder.sv
module addr_route_decoder import ard_pkg::*; #(
  parameter int ADDR_W = 46,
  parameter int NODES  = 2,
  parameter int RULES  = 24,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int IDX_W  = (RULES > 1) ? $clog2(RULES) : 1,
  localparam int LOW_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] low_top,
  input  logic [ADDR_W-1:0] high_top,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [NODE_W-1:0] cfg_node,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [2:0]        rsp_socket,
  output logic [2:0]        rsp_mc,
  output logic [1:0]        rsp_chan
);
  localparam logic [ADDR_W-1:0] FOUR_GIB = ADDR_W'(64'h1_0000_0000);
  localparam logic [ADDR_W-1:0] LOW_ONES = ADDR_W'({LOW_W{1'b1}});

  state_e              state_q;
  logic [ADDR_W-1:0]   addr_q, prev_q;
  logic [NODE_W-1:0]   node_q;
  logic [IDX_W-1:0]    idx_q;
  logic                hop_q;
  rule_t               hit_rule_q;
  logic [WORD_W-1:0]   hit_tgt_q;
  logic                err_q;
  logic [2:0]          sock_q, mc_q;
  logic [1:0]          ch_q;

  logic [WORD_W-1:0]   rd_rule_w, rd_tgt_w, rd_route_w;
  logic [3*NODES-1:0]  srcid_all;

  ard_rule_table #(.NODES(NODES), .RULES(RULES)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_kind  (cfg_kind),
    .wr_node  (cfg_node),
    .wr_idx   (cfg_idx),
    .wr_data  (cfg_data),
    .rd_node  (node_q),
    .rd_idx   (idx_q),
    .rd_rule  (rd_rule_w),
    .rd_tgt   (rd_tgt_w),
    .rd_route (rd_route_w),
    .srcid_all(srcid_all)
  );

  // range check on the incoming address
  logic out_of_range;
  assign out_of_range = (req_addr >= high_top) ||
                        ((req_addr >= low_top) && (req_addr < FOUR_GIB));

  // scan compare for the rule at idx_q
  rule_t             cur_rule;
  logic [ADDR_W-1:0] cur_limit;
  logic              cur_hit, last_rule;
  assign cur_rule  = rule_t'(rd_rule_w);
  assign cur_limit = (ADDR_W'(cur_rule.limit_f) << LOW_W) | LOW_ONES;
  assign cur_hit   = cur_rule.en && (addr_q >= prev_q) && (addr_q <= cur_limit);
  assign last_rule = (int'(idx_q) == RULES - 1);

  // target extraction for the latched rule
  logic [2:0] tix;
  logic [3:0] tgt;
  always_comb begin
    case (hit_rule_q.ilv_sel)
      2'd0: tix = addr_q[8:6];
      2'd1: tix = addr_q[10:8];
      2'd2: tix = addr_q[14:12];
      default: tix = addr_q[32:30];
    endcase
    tgt = hit_tgt_q[4*int'(tix) +: 4];
  end

  logic remote;
  assign remote = !tgt[3];

  // remote node lookup: lowest-numbered node with matching source id
  logic              node_found;
  logic [NODE_W-1:0] node_next;
  always_comb begin
    node_found = 1'b0;
    node_next  = '0;
    for (int n = NODES - 1; n >= 0; n--) begin
      if (srcid_all[3*n +: 3] == tgt[2:0]) begin
        node_found = 1'b1;
        node_next  = NODE_W'(n);
      end
    end
  end

  logic [2:0] lchan, pick_mc;
  logic [1:0] pick_ch;
  logic       fold_illegal;

  ard_chan_sel #(.ADDR_W(ADDR_W)) u_chan (
    .addr   (addr_q),
    .rule   (hit_rule_q),
    .tgt    (tgt),
    .lchan  (lchan),
    .illegal(fold_illegal)
  );

  ard_route_pick u_route (
    .route(rd_route_w),
    .lchan(lchan),
    .mc   (pick_mc),
    .chan (pick_ch)
  );

  logic [2:0] cur_sid;
  assign cur_sid = srcid_all[3*int'(node_q) +: 3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      prev_q     <= '0;
      node_q     <= '0;
      idx_q      <= '0;
      hop_q      <= 1'b0;
      hit_rule_q <= '0;
      hit_tgt_q  <= '0;
      err_q      <= 1'b0;
      sock_q     <= '0;
      mc_q       <= '0;
      ch_q       <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          prev_q <= '0;
          idx_q  <= '0;
          node_q <= '0;
          hop_q  <= 1'b0;
          err_q  <= 1'b0;
          sock_q <= '0;
          mc_q   <= '0;
          ch_q   <= '0;
          if (out_of_range) begin
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          prev_q <= cur_limit + 1'b1;
          if (cur_hit) begin
            hit_rule_q <= cur_rule;
            hit_tgt_q  <= rd_tgt_w;
            state_q    <= ST_RESOLVE;
          end else if (last_rule) begin
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_RESOLVE: begin
          if (remote) begin
            if (hop_q || !node_found) begin
              err_q   <= 1'b1;
              state_q <= ST_RESP;
            end else begin
              node_q  <= node_next;
              hop_q   <= 1'b1;
              idx_q   <= '0;
              prev_q  <= '0;
              state_q <= ST_SCAN;
            end
          end else if (fold_illegal) begin
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            sock_q  <= cur_sid;
            mc_q    <= pick_mc;
            ch_q    <= pick_ch;
            state_q <= ST_RESP;
          end
        end
        default: if (rsp_ready) state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = (state_q == ST_RESP);
  assign rsp_err    = err_q;
  assign rsp_socket = sock_q;
  assign rsp_mc     = mc_q;
  assign rsp_chan   = ch_q;

  // R11: never ready for a request while a result waits
  p_ready_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R11: an unaccepted result holds steady
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable({rsp_err, rsp_socket, rsp_mc, rsp_chan})));

  // R1: an address outside memory goes straight to an error result
  p_oor_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && out_of_range) |=> (rsp_valid && rsp_err));

  // R7: a second remote target ends in an error
  p_second_hop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESOLVE && hop_q && remote) |=> (rsp_valid && rsp_err));

  // R9: folded logical channel stays within six values
  p_fold_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESOLVE && hit_rule_q.fold_en && !remote) |-> (lchan < 3'd6));

  // R10: error results carry zero indices
  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_socket == 3'd0 && rsp_mc == 3'd0 && rsp_chan == 2'd0));
endmodule

// File: tb/addr_route_decoder_tb.sv
module addr_route_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 46;
  localparam int NN = 2;
  localparam int NR = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [AW-1:0] low_top  = AW'(64'h8000_0000);
  logic [AW-1:0] high_top = AW'(64'h100_0000_0000);
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_kind = '0;
  logic          cfg_node = '0;
  logic [4:0]    cfg_idx = '0;
  logic [31:0]   cfg_data = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic          rsp_err;
  logic [2:0]    rsp_socket, rsp_mc;
  logic [1:0]    rsp_chan;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_route_decoder #(.ADDR_W(AW), .NODES(NN), .RULES(NR)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .low_top(low_top), .high_top(high_top),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_node(cfg_node),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_socket(rsp_socket), .rsp_mc(rsp_mc), .rsp_chan(rsp_chan)
  );

  // bench-side copy of the configuration
  logic [31:0] m_rule [NN][NR];
  logic [31:0] m_tgt  [NN][NR];
  logic [2:0]  m_sid  [NN];
  logic [31:0] m_rte  [NN];

  function automatic logic [31:0] mk_rule(input bit en, input logic [1:0] ilv,
      input logic [1:0] mode, input bit fold, input logic [1:0] shc, input logic [19:0] f);
    return {shc, 2'b00, fold, f, mode, 2'b00, ilv, en};
  endfunction

  // expected {err, socket, mc, chan} derived from the requirements
  function automatic logic [8:0] model(input logic [AW-1:0] a);
    int node, hit, ix, sh;
    logic [AW-1:0] prev, lim, x;
    logic [3:0] t;
    logic [1:0] v;
    logic [2:0] l;
    logic [63:0] ext;
    bit found;
    if (a >= high_top || (a >= low_top && a < AW'(64'h1_0000_0000))) return 9'h100;
    node = 0;
    for (int pass = 0; pass < 2; pass++) begin
      prev = '0;
      hit = -1;
      for (int r = 0; r < NR; r++) begin
        lim = (AW'(m_rule[node][r][26:7]) << 26) | AW'(26'h3FF_FFFF);
        if (hit < 0 && m_rule[node][r][0] && a >= prev && a <= lim) hit = r;
        prev = lim + 1;
      end
      if (hit < 0) return 9'h100;
      case (m_rule[node][hit][2:1])
        2'd0: ix = int'(a[8:6]);
        2'd1: ix = int'(a[10:8]);
        2'd2: ix = int'(a[14:12]);
        default: ix = int'(a[32:30]);
      endcase
      t = m_tgt[node][hit][4*ix +: 4];
      if (!t[3]) begin
        if (pass == 1) return 9'h100;
        found = 0;
        for (int n = 0; n < NN; n++)
          if (!found && m_sid[n] == t[2:0]) begin found = 1; node = n; end
        if (!found) return 9'h100;
      end else begin
        if (m_rule[node][hit][27]) begin
          case (m_rule[node][hit][31:30])
            2'd0: sh = 6;
            2'd1: sh = 8;
            2'd2: sh = 12;
            default: return 9'h100;
          endcase
          x = a >> sh;
          case (m_rule[node][hit][6:5])
            2'd0: v = 2'(x % 3);
            2'd1: v = 2'(x % 2);
            2'd2: v = (x % 2 == 1) ? 2'd2 : 2'd1;
            default: v = (x % 2 == 1) ? 2'd2 : 2'd0;
          endcase
          l = {v, t[0]};
        end else begin
          l = t[2:0];
        end
        ext = {32'b0, m_rte[node]};
        return {1'b0, m_sid[node], 3'(ext >> (3*int'(l))), 2'(ext >> (2*int'(l) + 18))};
      end
    end
    return 9'h100;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] kind, input int node, input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = kind; cfg_node = 1'(node); cfg_idx = 5'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (kind)
      2'd0: m_rule[node][idx] = d;
      2'd1: m_tgt[node][idx] = d;
      2'd2: m_sid[node] = d[2:0];
      default: m_rte[node] = d;
    endcase
  endtask

  task automatic issue(input logic [AW-1:0] a, output logic [8:0] got);
    @(negedge clk);
    req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200 && !rsp_valid; i++) @(negedge clk);
    got = {rsp_err, rsp_socket, rsp_mc, rsp_chan};
    if (!rsp_valid) got = 9'h1FF;
  endtask

  task automatic release_rsp();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic check_dec(input string req, input logic [AW-1:0] a);
    logic [8:0] got, exp;
    exp = model(a);
    issue(a, got);
    chk(got == exp, req, 32'(got), 32'(exp));
    release_rsp();
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R11 reset ready", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R11 reset valid", 32'(rsp_valid), 0);
  endtask

  task automatic t_config();
    for (int n = 0; n < NN; n++) begin
      m_sid[n] = 3'(n); m_rte[n] = '0;
      for (int r = 0; r < NR; r++) begin m_rule[n][r] = '0; m_tgt[n][r] = '0; end
    end
    // R12: default state, nothing enabled -> miss
    check_dec("R12 reset rules disabled", AW'(64'h100));
    cfg_write(2'd3, 0, 0, 32'hB4E1_9A37);
    cfg_write(2'd3, 1, 0, 32'h2C7D_05E6);
    cfg_write(2'd2, 1, 0, 32'h5);
    cfg_write(2'd0, 0, 0, mk_rule(0, 0, 0, 0, 0, 20'h1));
    cfg_write(2'd0, 0, 1, mk_rule(1, 0, 0, 0, 0, 20'h2));
    cfg_write(2'd0, 0, 2, mk_rule(1, 3, 0, 0, 0, 20'h50));
    cfg_write(2'd0, 0, 3, mk_rule(1, 1, 0, 1, 0, 20'h60));
    cfg_write(2'd0, 0, 4, mk_rule(1, 2, 1, 1, 1, 20'h70));
    cfg_write(2'd0, 0, 5, mk_rule(1, 0, 2, 1, 2, 20'h80));
    cfg_write(2'd0, 0, 6, mk_rule(1, 0, 3, 1, 0, 20'h90));
    cfg_write(2'd0, 0, 7, mk_rule(1, 0, 0, 1, 3, 20'hA0));
    cfg_write(2'd0, 0, 8, mk_rule(1, 0, 0, 0, 0, 20'hB0));
    cfg_write(2'd0, 0, 9, mk_rule(1, 0, 0, 0, 0, 20'hC0));
    for (int r = 0; r < 8; r++) cfg_write(2'd1, 0, r, 32'hFEDC_BA98);
    cfg_write(2'd1, 0, 8, 32'h5555_5555);
    cfg_write(2'd1, 0, 9, 32'h3333_3333);
    cfg_write(2'd0, 1, 0, mk_rule(1, 1, 0, 0, 0, 20'hAC));
    cfg_write(2'd0, 1, 1, mk_rule(1, 0, 0, 0, 0, 20'hFF));
    cfg_write(2'd1, 1, 0, 32'h98BA_DCFE);
    cfg_write(2'd1, 1, 1, 32'h0000_0000);
  endtask

  task automatic t_range();
    logic [8:0] got;
    check_dec("R1 between low top and 4GiB", AW'(64'h9000_0000));
    check_dec("R1 at high top", AW'(64'h100_0000_0000));
    check_dec("R1 exactly 4GiB decodes", AW'(64'h1_0000_0000));
    issue(AW'(64'hC000_0000), got);
    chk(got[8] == 1'b1, "R1 error flag", 32'(got), 32'h100);
    release_rsp();
  endtask

  task automatic t_order();
    check_dec("R2 address in disabled rule misses", AW'(64'h7FF_FFFF));
    check_dec("R2 lower bound from disabled rule", AW'(64'h800_0000));
    check_dec("R2 upper bound inclusive", AW'(64'hBFF_FFFF));
    check_dec("R2 next rule after bound", AW'(64'hC00_0000));
    check_dec("R3 miss past last enabled rule", AW'(64'h3_1000_0000));
  endtask

  task automatic t_interleave();
    check_dec("R4 code0 bits 8:6", AW'(64'h800_0140));
    check_dec("R4 code3 bits 32:30", AW'(64'h1_2000_0000));
    check_dec("R4 code1 bits 10:8", AW'(64'h1_4400_0500));
    check_dec("R5 R8 R10 local target lchan", AW'(64'h800_01C0));
  endtask

  task automatic t_fold();
    check_dec("R9 mod3 shift6 a", AW'(64'h1_4400_0000));
    check_dec("R9 mod3 shift6 b", AW'(64'h1_5ABC_DE40));
    check_dec("R9 mod3 shift6 c", AW'(64'h1_7FFF_FFC0));
    check_dec("R9 mod3 shift6 d", AW'(64'h1_6123_4567));
    check_dec("R9 mod2 shift8 a", AW'(64'h1_8400_0100));
    check_dec("R9 mod2 shift8 b", AW'(64'h1_9000_0000));
    check_dec("R9 pair form shift12 a", AW'(64'h2_0000_1000));
    check_dec("R9 pair form shift12 b", AW'(64'h1_F000_0000));
    check_dec("R9 shifted-odd form a", AW'(64'h2_0400_0040));
    check_dec("R9 shifted-odd form b", AW'(64'h2_1000_0000));
    check_dec("R9 illegal shift code", AW'(64'h2_5000_0000));
  endtask

  task automatic t_remote();
    logic [8:0] got;
    issue(AW'(64'h2_9000_0000), got);
    chk(got[8] == 1'b0 && got[7:5] == 3'd5, "R6 remote socket", 32'(got), 32'(model(AW'(64'h2_9000_0000))));
    release_rsp();
    check_dec("R6 remote hop full result", AW'(64'h2_9000_0140));
    check_dec("R7 second remote", AW'(64'h2_C000_0000));
    check_dec("R7 unknown node", AW'(64'h2_D000_0000));
    // R12: rename node 1 and make its second rule local
    cfg_write(2'd2, 1, 0, 32'h3);
    cfg_write(2'd1, 1, 1, 32'hFEDC_BA98);
    check_dec("R12 rewritten source id routes", AW'(64'h2_D000_0080));
  endtask

  task automatic t_handshake();
    logic [8:0] got, held;
    bit stable_ok;
    issue(AW'(64'h800_0140), got);
    chk(req_ready == 1'b0, "R11 ready low while pending", 32'(req_ready), 0);
    stable_ok = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      held = {rsp_err, rsp_socket, rsp_mc, rsp_chan};
      if (!rsp_valid || held != got) stable_ok = 0;
    end
    chk(stable_ok, "R11 result held", 32'(held), 32'(got));
    release_rsp();
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R11 released", 32'({rsp_valid, req_ready}), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_range();
    t_order();
    t_interleave();
    t_fold();
    t_remote();
    t_handshake();
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule